// File: doc/BRIEF.md
# Entropy-Bit SPI Streamer

This block hands a raw random bit stream to an external SPI master. A single-bit entropy input, produced asynchronously by a bank of free-running oscillators, is registered into the fabric clock domain. The master's serial clock and chip select are brought into that domain through synchronisers, and the block finds their edges there. Each time the serial clock falls while the block is selected, the output register takes a freshly sampled random bit. The master then reads it on the next rising edge, as in SPI mode 0.

The stream has no command, address or word boundary. Each serial clock cycle yields one new bit for as long as chip select stays low. When chip select goes low, the first bit is the one sampled at that moment, so the master's first rising edge already has valid data. When deselected, the output enable is low and the data line reads 0. The fabric clock must be several times faster than the serial clock, because every edge passes through a synchroniser before it acts.

Top module: `rng_spi_streamer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sdo_oe` and `sdo` are both 0. A reset in the middle of a transfer also clears them.
- R2: While `cs_n` is high, `sdo_oe` stays 0 and `sdo` stays 0. Serial clock edges in that state change neither output.
- R3: When `cs_n` goes low, `sdo_oe` rises within 3 fabric clocks. At the same time `sdo` takes the value `rnd_in` held across the assertion. No serial clock edge is needed for this.
- R4: At each falling `sck` edge while selected, `sdo` takes the value that `rnd_in` held across that edge, within 3 fabric clocks.
- R5: A rising `sck` edge never changes `sdo`, even if `rnd_in` differs from the bit on `sdo`.
- R6: Between two falling `sck` edges, `sdo` holds its value regardless of changes on `rnd_in`.
- R7: If `cs_n` rises in the same fabric cycle that `sck` falls, the release wins: `sdo_oe` and `sdo` go to 0 and no new bit is loaded.
- R8: Consecutive falling edges deliver consecutive input bits in order, one bit per serial clock cycle, with no bit skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, several times faster than `sck` |
| rst | input | 1 | Synchronous active-high reset |
| rnd_in | input | 1 | Raw random bit from the asynchronous entropy source |
| sck | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Chip select from the master, active low |
| sdo | output | 1 | Serial data to the master, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the pad driver of `sdo` |

## Verification
Two events can reach the output register in the same fabric cycle: a synchronised chip-select change and a synchronised serial-clock fall. The bench provokes this by changing `cs_n` and `sck` in the same fabric cycle. In one case the master releases select at the moment the clock falls, and the block is judged on whether both outputs drop to 0. In the other case select is asserted while the clock falls from high, and the block is judged on whether it enables the output with the bit present on `rnd_in` at that moment.

// File: rtl/rng_spi_pkg.sv
package rng_spi_pkg;

    // Edge pulses of the synchronised serial clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_ev_t;

    // Chip-select state and its transitions in the fabric domain.
    typedef struct packed {
        logic active;
        logic start;
        logic stop;
    } sel_ev_t;

    // Output stage state: pad enable plus data bit.
    typedef struct packed {
        logic en;
        logic data;
    } sdo_reg_t;

    typedef enum logic [1:0] {
        LD_HOLD   = 2'd0,
        LD_CLEAR  = 2'd1,
        LD_SAMPLE = 2'd2
    } ld_op_t;

    localparam sdo_reg_t SDO_IDLE = '{en: 1'b0, data: 1'b0};

    function automatic sck_ev_t classify_edge(input logic prev, input logic cur);
        sck_ev_t ev;
        ev.rise = ~prev & cur;
        ev.fall = prev & ~cur;
        return ev;
    endfunction

    // Release has priority; otherwise select start or a falling edge samples.
    function automatic ld_op_t pick_op(input sel_ev_t sel, input sck_ev_t ev);
        if (!sel.active || sel.stop)
            return LD_CLEAR;
        else if (sel.start || ev.fall)
            return LD_SAMPLE;
        else
            return LD_HOLD;
    endfunction

endpackage

// File: rtl/rng_sync.sv
module rng_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rng_event_detect.sv
module rng_event_detect
    import rng_spi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_s,
    input  logic    cs_n_s,
    output sck_ev_t sck_ev,
    output sel_ev_t sel_ev
);
    logic sck_prev;
    logic cs_n_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev  <= 1'b0;
            cs_n_prev <= 1'b1;
        end else begin
            sck_prev  <= sck_s;
            cs_n_prev <= cs_n_s;
        end
    end

    always_comb begin
        sck_ev        = classify_edge(sck_prev, sck_s);
        sel_ev.active = ~cs_n_s;
        sel_ev.start  = cs_n_prev & ~cs_n_s;
        sel_ev.stop   = ~cs_n_prev & cs_n_s;
    end
endmodule

// File: rtl/rng_sdo_stage.sv
module rng_sdo_stage
    import rng_spi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sel_ev_t sel_ev,
    input  sck_ev_t sck_ev,
    input  logic    rnd,
    output logic    sdo,
    output logic    sdo_oe
);
    sdo_reg_t state_q;
    sdo_reg_t state_d;
    ld_op_t   op;

    always_comb begin
        op      = pick_op(sel_ev, sck_ev);
        state_d = state_q;
        unique case (op)
            LD_CLEAR:  state_d = SDO_IDLE;
            LD_SAMPLE: state_d = '{en: 1'b1, data: rnd};
            default:   state_d.en = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SDO_IDLE;
        else     state_q <= state_d;
    end

    assign sdo    = state_q.en & state_q.data;
    assign sdo_oe = state_q.en;
endmodule

// File: rtl/rng_spi_streamer.sv
module rng_spi_streamer
    import rng_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RND_STAGES  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rnd_in,
    input  logic sck,
    input  logic cs_n,
    output logic sdo,
    output logic sdo_oe
);
    localparam logic [1:0] CTRL_RST = 2'b01; // {sck, cs_n}: idle low, deselected

    logic [1:0] ctrl_s;
    logic       rnd_q;
    sck_ev_t    sck_ev;
    sel_ev_t    sel_ev;

    rng_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_ctrl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, cs_n}),
        .q   (ctrl_s)
    );

    rng_sync #(.W(1), .STAGES(RND_STAGES), .RST_VAL(1'b0)) u_rnd_sync (
        .clk (clk),
        .rst (rst),
        .d   (rnd_in),
        .q   (rnd_q)
    );

    rng_event_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (ctrl_s[1]),
        .cs_n_s (ctrl_s[0]),
        .sck_ev (sck_ev),
        .sel_ev (sel_ev)
    );

    rng_sdo_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .sel_ev (sel_ev),
        .sck_ev (sck_ev),
        .rnd    (rnd_q),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );
endmodule

// File: rtl/rng_spi_streamer_chk.sv
module rng_spi_streamer_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sdo,
    input logic sdo_oe,
    input logic sck_rise,
    input logic sck_fall,
    input logic sel_active,
    input logic sel_start,
    input logic rnd_q
);
    // R2: three samples of a high select keep the pad disabled
    p_quiet_deselect_r2: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n, 3) |-> !sdo_oe);

    // R3: select start enables the pad with the current random bit
    p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
        sel_start |=> (sdo_oe && sdo == $past(rnd_q)));

    // R4: a falling edge while selected loads the current random bit
    p_fall_load_r4: assert property (@(posedge clk) disable iff (rst)
        (sck_fall && sel_active) |=> (sdo == $past(rnd_q)));

    // R5: a rising edge with a steady select leaves the data line unchanged
    p_rise_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sck_rise && sel_active && !sel_start) |=> $stable(sdo));

    // R7: release wins over any simultaneous edge
    p_release_wins_r7: assert property (@(posedge clk) disable iff (rst)
        !sel_active |=> (!sdo_oe && !sdo));
endmodule

bind rng_spi_streamer rng_spi_streamer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .sck_rise   (sck_ev.rise),
    .sck_fall   (sck_ev.fall),
    .sel_active (sel_ev.active),
    .sel_start  (sel_ev.start),
    .rnd_q      (rnd_q)
);

// File: tb/rng_spi_streamer_tb.sv
module rng_spi_streamer_tb;
    logic clk = 1'b0;
    logic rst;
    logic rnd_in;
    logic sck;
    logic cs_n;
    logic sdo;
    logic sdo_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // {stimulus bit, expected bit on sdo at the following rising edge}
    localparam logic [1:0] VEC [0:11] = '{
        2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11,
        2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00
    };

    always #10 clk = ~clk;

    rng_spi_streamer u_dut (
        .clk    (clk),
        .rst    (rst),
        .rnd_in (rnd_in),
        .sck    (sck),
        .cs_n   (cs_n),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; rnd_in = 1'b0;
        tick(3);
        check("R1", "oe in reset", sdo_oe, 1'b0);
        check("R1", "sdo in reset", sdo, 1'b0);
        rst = 1'b0;
        tick(1);
        check("R1", "oe after reset", sdo_oe, 1'b0);
        tick(1);

        // R2: deselected, clock toggles ignored
        rnd_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sck = ~sck;
            tick(5);
            check("R2", "oe deselected", sdo_oe, 1'b0);
            check("R2", "sdo deselected", sdo, 1'b0);
        end

        // R3: select start loads the present bit
        sck = 1'b0;
        tick(4);
        rnd_in = 1'b1;
        tick(3);
        cs_n = 1'b0;
        tick(4);
        check("R3", "oe after select", sdo_oe, 1'b1);
        check("R3", "first bit", sdo, 1'b1);
        rnd_in = 1'b0;
        tick(4);
        check("R6", "hold before first rise", sdo, 1'b1);
        sck = 1'b1;
        tick(4);
        check("R5", "first rise no load", sdo, 1'b1);

        // R4/R8: streamed vector walk
        for (int i = 0; i < 12; i++) begin
            rnd_in = VEC[i][1];
            tick(4);
            sck = 1'b0;
            tick(4);
            check("R4", $sformatf("R8 bit %0d at fall", i), sdo, VEC[i][0]);
            rnd_in = ~VEC[i][1];
            tick(4);
            check("R6", $sformatf("hold bit %0d", i), sdo, VEC[i][0]);
            sck = 1'b1;
            tick(4);
            check("R5", $sformatf("rise bit %0d", i), sdo, VEC[i][0]);
        end

        // R7: release coincides with falling edge
        rnd_in = 1'b1;
        tick(4);
        cs_n = 1'b1;
        sck  = 1'b0;
        tick(4);
        check("R7", "oe on release+fall", sdo_oe, 1'b0);
        check("R7", "sdo on release+fall", sdo, 1'b0);

        // R3: select start coincides with falling edge
        sck = 1'b1;
        tick(5);
        rnd_in = 1'b1;
        tick(4);
        cs_n = 1'b0;
        sck  = 1'b0;
        tick(4);
        check("R3", "oe on start+fall", sdo_oe, 1'b1);
        check("R3", "sdo on start+fall", sdo, 1'b1);

        // R1: reset in mid-transfer, then fresh start with select held low
        rst    = 1'b1;
        rnd_in = 1'b0;
        tick(2);
        check("R1", "oe mid reset", sdo_oe, 1'b0);
        check("R1", "sdo mid reset", sdo, 1'b0);
        rst = 1'b0;
        tick(4);
        check("R3", "oe after reset restart", sdo_oe, 1'b1);
        check("R3", "sdo after reset restart", sdo, 1'b0);

        cs_n = 1'b1;
        tick(4);
        check("R2", "oe final release", sdo_oe, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule